// File: doc/BRIEF.md
# Multi-Mode Timer Time Base

This block is the counting core of a general timer. It divides the input clock with a programmable prescaler, then steps a counter that is bounded by an auto-reload limit. The counter can count up and wrap, count down and reload, or count up and down between zero and the limit. It raises an update event each time the counter wraps, and also when software asks for one. Compare channels placed next to it use the exported count. They also use the current direction and a window flag that says whether compare matches may set their flags in the present phase.

Software drives the block through single-cycle write strobes. One strobe writes the control fields together: enable, counting mode, direction, reload preload, update source, interrupt enable and DMA request enable. Other strobes write the prescaler value, write the reload value, generate an update, clear the counter and clear the update flag. The update flag drives an interrupt line through its own enable. Each qualifying update event gives a one-cycle DMA request pulse through a separate enable.

Top module: `tmb_top`

## Requirements
- R1: With mode 0 (edge) and direction 0 (up), the counter steps from 0 to the effective limit and then goes back to 0. The period is (prescaler+1)×(limit+1) clocks, and a counter update event occurs at each wrap.
- R2: With mode 0 and direction 1 (down), the counter steps down to 0. On the next step it loads the reload register value, which is an update event.
- R3: Modes 1, 2 and 3 count up to the limit and then down to 0. There is an update event at the peak, where the direction turns to down, and another at the valley, where the direction turns to up.
- R4: dir_o is 1 while counting down. cmp_win_o is always 1 in modes 0 and 3, equals dir_o in mode 1, and equals the inverse of dir_o in mode 2.
- R5: A control write while the counter is enabled updates every field except mode and direction, which keep their values.
- R6: With preload set, a new reload value takes effect at the next update event. With preload clear, it takes effect at once.
- R7: An update-generation pulse restarts the prescaler at 0 and sets the counter to 0, or to the reload value in edge down mode. The next count step then follows a full prescaler period.
- R8: With update source 1 (counter only), an update-generation pulse sets neither the flag nor the DMA pulse. With source 0 it sets the flag.
- R9: The update flag stays set until a clear strobe, and a new event wins over a clear in the same cycle. irq_o equals the flag ANDed with the interrupt enable.
- R10: dma_o is a one-cycle pulse in the cycle after each flag-setting update event, and it is gated by the DMA enable.
- R11: With the enable clear, the count holds. A counter-clear strobe sets the count to 0.
- R12: A new prescaler value is taken by the divider only at an update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control field write strobe |
| en_i | input | 1 | Counter enable field |
| mode_i | input | 2 | Counting mode: 0 edge, 1 center with down-phase compares, 2 center with up-phase compares, 3 center with both |
| dir_i | input | 1 | Edge mode direction, 1 = down |
| arpe_i | input | 1 | Reload preload enable |
| urs_i | input | 1 | Update source: 1 = counter wrap only |
| uie_i | input | 1 | Update interrupt enable |
| ude_i | input | 1 | Update DMA request enable |
| psc_we_i | input | 1 | Prescaler write strobe |
| arr_we_i | input | 1 | Reload value write strobe |
| wdata_i | input | DW | Write data for the prescaler and reload strobes |
| ug_i | input | 1 | Software update generation pulse |
| cnt_clr_i | input | 1 | Counter clear strobe |
| flag_clr_i | input | 1 | Update flag clear strobe |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Current direction, 1 = down |
| cmp_win_o | output | 1 | Compare flags allowed in this phase |
| uif_o | output | 1 | Update flag |
| irq_o | output | 1 | Update interrupt |
| dma_o | output | 1 | Update DMA request pulse |

## Verification
The assertions assume that every strobe is synchronous to clk_i and settled before the rising edge. They do not assume that strobes are exclusive, so an update pulse, a counter clear and a flag clear may all fall in the same cycle. The stimulus changes every input only at the falling edge. Its random part keeps the limits and prescaler values small, so many wraps happen, and it mixes update pulses, clears and writes made while the counter runs. The directed part pins down exact cycle counts for the periods, the preload timing and the restart after an update pulse.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  typedef enum logic [1:0] {
    CM_EDGE     = 2'd0,
    CM_CTR_DN   = 2'd1,
    CM_CTR_UP   = 2'd2,
    CM_CTR_BOTH = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/tmb_presc.sv
module tmb_presc #(
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             reinit_i,
  input  logic             load_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [PSC_W-1:0] P_ONE = PSC_W'(1);

  logic [PSC_W-1:0] pc_q, div_q;

  assign tick_o = run_i & ~reinit_i & (pc_q == div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      div_q <= '0;
    end else begin
      if (reinit_i)   pc_q <= '0;
      else if (run_i) pc_q <= (pc_q == div_q) ? '0 : pc_q + P_ONE;
      // divider shadow only moves on update events
      if (load_i) div_q <= div_i;
    end
  end
endmodule

// File: rtl/tmb_core.sv
module tmb_core
  import tmb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ug_i,
  input  logic             clr_i,
  input  cnt_mode_e        mode_i,
  input  logic             dn_ld_i,
  input  logic             dn_val_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic [CNT_W-1:0] nlim_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dn_o,
  output logic             ev_o
);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             dn_q, dn_nx, at, edge_m, lim_z;

  assign edge_m = (mode_i == CM_EDGE);
  assign lim_z  = (lim_i == '0);
  // boundary: bottom when descending, limit or above when ascending
  assign at     = dn_q ? (cnt_q == '0) : (cnt_q >= lim_i);
  assign ev_o   = tick_i & at;

  always_comb begin
    cnt_nx = cnt_q;
    dn_nx  = dn_q;
    if (!at)         cnt_nx = dn_q ? cnt_q - C_ONE : cnt_q + C_ONE;
    else if (edge_m) cnt_nx = dn_q ? nlim_i : '0;
    else if (dn_q) begin
      cnt_nx = lim_z ? '0 : C_ONE;
      dn_nx  = 1'b0;
    end else begin
      cnt_nx = lim_z ? '0 : lim_i - C_ONE;
      dn_nx  = ~lim_z;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      if (ug_i)        cnt_q <= (edge_m & dn_q) ? nlim_i : '0;
      else if (clr_i)  cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_nx;

      if (ug_i)                       dn_q <= edge_m ? dn_q : 1'b0;
      else if (dn_ld_i)               dn_q <= dn_val_i;
      else if (tick_i & at & ~edge_m) dn_q <= dn_nx;
    end
  end

  assign cnt_o = cnt_q;
  assign dn_o  = dn_q;
endmodule

// File: rtl/tmb_upd.sv
module tmb_upd #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arpe_i,
  input  logic             urs_i,
  input  logic             ude_i,
  input  logic             arr_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             ev_i,
  input  logic             ug_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] lim_o,
  output logic [CNT_W-1:0] nlim_o,
  output logic             uif_o,
  output logic             dma_o
);
  logic [CNT_W-1:0] arr_q, ash_q;
  logic             uif_q, dma_q, set_flag;

  assign set_flag = ev_i | (ug_i & ~urs_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_q <= '1;
      ash_q <= '1;
      uif_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      if (arr_we_i) arr_q <= wdata_i;
      // shadow follows the register when preload is off
      if (ev_i | ug_i | ~arpe_i) ash_q <= arr_q;
      if (set_flag)        uif_q <= 1'b1;
      else if (flag_clr_i) uif_q <= 1'b0;
      dma_q <= set_flag & ude_i;
    end
  end

  assign lim_o  = arpe_i ? ash_q : arr_q;
  assign nlim_o = arr_q;
  assign uif_o  = uif_q;
  assign dma_o  = dma_q;
endmodule

// File: rtl/tmb_top.sv
module tmb_top
  import tmb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  localparam int DW   = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic             dir_i,
  input  logic             arpe_i,
  input  logic             urs_i,
  input  logic             uie_i,
  input  logic             ude_i,
  input  logic             psc_we_i,
  input  logic             arr_we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ug_i,
  input  logic             cnt_clr_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             cmp_win_o,
  output logic             uif_o,
  output logic             irq_o,
  output logic             dma_o
);
  logic             en_q, arpe_q, urs_q, uie_q, ude_q;
  cnt_mode_e        mode_q, mode_new;
  logic [PSC_W-1:0] psc_q;
  logic             mode_ld, tick, cnt_ev, dn;
  logic [CNT_W-1:0] lim, nlim;

  assign mode_new = cnt_mode_e'(mode_i);
  // geometry is frozen while counting
  assign mode_ld  = ctl_we_i & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      arpe_q <= 1'b0;
      urs_q  <= 1'b0;
      uie_q  <= 1'b0;
      ude_q  <= 1'b0;
      mode_q <= CM_EDGE;
      psc_q  <= '0;
    end else begin
      if (ctl_we_i) begin
        en_q   <= en_i;
        arpe_q <= arpe_i;
        urs_q  <= urs_i;
        uie_q  <= uie_i;
        ude_q  <= ude_i;
      end
      if (mode_ld)  mode_q <= mode_new;
      if (psc_we_i) psc_q  <= wdata_i[PSC_W-1:0];
    end
  end

  tmb_presc #(.PSC_W(PSC_W)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (en_q),
    .reinit_i (ug_i),
    .load_i   (cnt_ev | ug_i),
    .div_i    (psc_q),
    .tick_o   (tick)
  );

  tmb_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .ug_i     (ug_i),
    .clr_i    (cnt_clr_i),
    .mode_i   (mode_q),
    .dn_ld_i  (mode_ld),
    .dn_val_i ((mode_new == CM_EDGE) & dir_i),
    .lim_i    (lim),
    .nlim_i   (nlim),
    .cnt_o    (cnt_o),
    .dn_o     (dn),
    .ev_o     (cnt_ev)
  );

  tmb_upd #(.CNT_W(CNT_W)) u_upd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arpe_i     (arpe_q),
    .urs_i      (urs_q),
    .ude_i      (ude_q),
    .arr_we_i   (arr_we_i),
    .wdata_i    (wdata_i[CNT_W-1:0]),
    .ev_i       (cnt_ev),
    .ug_i       (ug_i),
    .flag_clr_i (flag_clr_i),
    .lim_o      (lim),
    .nlim_o     (nlim),
    .uif_o      (uif_o),
    .dma_o      (dma_o)
  );

  always_comb begin
    unique case (mode_q)
      CM_CTR_DN: cmp_win_o = dn;
      CM_CTR_UP: cmp_win_o = ~dn;
      default:   cmp_win_o = 1'b1;
    endcase
  end

  assign dir_o = dn;
  assign irq_o = uif_o & uie_q;
endmodule

// File: rtl/tmb_chk.sv
module tmb_chk
  import tmb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input cnt_mode_e        mode_q,
  input logic             en_q,
  input logic             urs_q,
  input logic             ude_q,
  input logic             tick_i,
  input logic             ev_i,
  input logic [CNT_W-1:0] lim_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             dir_o,
  input logic             ug_i,
  input logic             cnt_clr_i,
  input logic             flag_clr_i,
  input logic             ctl_we_i,
  input logic             uif_o,
  input logic             dma_o
);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  // R1
  edge_up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == CM_EDGE && !dir_o && tick_i && !ug_i && !cnt_clr_i && cnt_o < lim_i)
    |=> cnt_o == $past(cnt_o) + C_ONE);

  // R3
  peak_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != CM_EDGE && ev_i && !dir_o && !ug_i && lim_i != '0) |=> dir_o);

  // R5
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && ctl_we_i) |=> $stable(mode_q));

  // R7
  ug_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ug_i && !(mode_q == CM_EDGE && dir_o)) |=> cnt_o == '0);

  // R8
  urs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ug_i && urs_q && !uif_o && !ev_i) |=> !uif_o);

  // R9
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !ev_i && !(ug_i && !urs_q)) |=> !uif_o);

  // R10
  dma_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_o |-> $past(ude_q));

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !ug_i && !cnt_clr_i) |=> $stable(cnt_o));
endmodule

bind tmb_top tmb_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_q     (mode_q),
  .en_q       (en_q),
  .urs_q      (urs_q),
  .ude_q      (ude_q),
  .tick_i     (tick),
  .ev_i       (cnt_ev),
  .lim_i      (lim),
  .cnt_o      (cnt_o),
  .dir_o      (dir_o),
  .ug_i       (ug_i),
  .cnt_clr_i  (cnt_clr_i),
  .flag_clr_i (flag_clr_i),
  .ctl_we_i   (ctl_we_i),
  .uif_o      (uif_o),
  .dma_o      (dma_o)
);

// File: tb/sim_tmb_top.sv
`timescale 1ns/1ps
module sim_tmb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_we_i = 0, en_i = 0, dir_i = 0, arpe_i = 0, urs_i = 0, uie_i = 0, ude_i = 0;
  logic [1:0]  mode_i = 0;
  logic        psc_we_i = 0, arr_we_i = 0, ug_i = 0, cnt_clr_i = 0, flag_clr_i = 0;
  logic [15:0] wdata_i = 0;
  logic [15:0] cnt_o;
  logic        dir_o, cmp_win_o, uif_o, irq_o, dma_o;

  always #2 clk_i = ~clk_i;

  tmb_top u0 (.*);

  int total = 0, bad = 0;
  bit chk_on = 0, done = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // reference model, written from the requirements
  logic [15:0] m_cnt, m_pc, m_psh, m_ash, m_arr, m_psc, lim, ncnt;
  logic        m_dn, m_en, m_arpe, m_urs, m_uie, m_ude, m_uif, m_dma;
  logic [1:0]  m_mode;
  logic        tick, at, ev, setf, edm, ndn;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_cnt = 0; m_pc = 0; m_psh = 0; m_ash = 16'hFFFF; m_arr = 16'hFFFF; m_psc = 0;
      m_dn = 0; m_en = 0; m_arpe = 0; m_urs = 0; m_uie = 0; m_ude = 0; m_uif = 0; m_dma = 0;
      m_mode = 0;
    end else begin
      tick = m_en && (m_pc == m_psh) && !ug_i;
      lim  = m_arpe ? m_ash : m_arr;
      edm  = (m_mode == 0);
      at   = m_dn ? (m_cnt == 0) : (m_cnt >= lim);
      ev   = tick && at;
      setf = ev || (ug_i && !m_urs);
      ncnt = m_cnt; ndn = m_dn;
      if (ug_i) begin
        ncnt = (edm && m_dn) ? m_arr : 16'd0;
        ndn  = edm ? m_dn : 1'b0;
      end else begin
        if (ctl_we_i && !m_en) ndn = (mode_i == 0) ? dir_i : 1'b0;
        if (tick && at && !edm) ndn = m_dn ? 1'b0 : (lim != 0);
        if (cnt_clr_i) ncnt = 0;
        else if (tick) begin
          if (!at)       ncnt = m_dn ? m_cnt - 16'd1 : m_cnt + 16'd1;
          else if (edm)  ncnt = m_dn ? m_arr : 16'd0;
          else if (m_dn) ncnt = (lim == 0) ? 16'd0 : 16'd1;
          else           ncnt = (lim == 0) ? 16'd0 : lim - 16'd1;
        end
      end
      if (ug_i) m_pc = 0;
      else if (m_en) m_pc = (m_pc == m_psh) ? 16'd0 : m_pc + 16'd1;
      if (ev || ug_i) m_psh = m_psc;
      if (ev || ug_i || !m_arpe) m_ash = m_arr;
      if (setf) m_uif = 1; else if (flag_clr_i) m_uif = 0;
      m_dma = setf && m_ude;
      m_cnt = ncnt; m_dn = ndn;
      if (psc_we_i) m_psc = wdata_i;
      if (arr_we_i) m_arr = wdata_i;
      if (ctl_we_i) begin
        if (!m_en) m_mode = mode_i;
        m_en = en_i; m_arpe = arpe_i; m_urs = urs_i; m_uie = uie_i; m_ude = ude_i;
      end
    end
  end

  function automatic int exp_win(input logic [1:0] md, input logic dn);
    if (md == 1) return int'(dn);
    if (md == 2) return int'(!dn);
    return 1;
  endfunction

  always @(negedge clk_i) begin
    if (chk_on && rst_ni) begin
      string rq;
      rq = (m_mode != 0) ? "R3" : (m_dn ? "R2" : "R1");
      chk({rq, " model cnt"}, cnt_o, m_cnt);
      chk("R4 model dir", dir_o, m_dn);
      chk("R4 model window", cmp_win_o, exp_win(m_mode, m_dn));
      chk("R9 model flag", uif_o, m_uif);
      chk("R9 model irq", irq_o, m_uif & m_uie);
      chk("R10 model dma", dma_o, m_dma);
    end
  end

  task automatic ctl(input bit en, input bit [1:0] md, input bit dr, input bit ap,
                     input bit us, input bit ie, input bit de);
    ctl_we_i = 1; en_i = en; mode_i = md; dir_i = dr; arpe_i = ap; urs_i = us; uie_i = ie; ude_i = de;
    @(negedge clk_i);
    ctl_we_i = 0;
  endtask
  task automatic wr_psc(input int v);
    psc_we_i = 1; wdata_i = 16'(v); @(negedge clk_i); psc_we_i = 0;
  endtask
  task automatic wr_arr(input int v);
    arr_we_i = 1; wdata_i = 16'(v); @(negedge clk_i); arr_we_i = 0;
  endtask
  task automatic pulse_ug();
    ug_i = 1; @(negedge clk_i); ug_i = 0;
  endtask
  task automatic gap(output int n);
    do @(negedge clk_i); while (!dma_o);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!dma_o);
  endtask
  task automatic to_pulse(output int mx);
    mx = cnt_o;
    do begin @(negedge clk_i); if (cnt_o > mx) mx = cnt_o; end while (!dma_o);
  endtask

  initial begin
    #800000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, mx, v, seed;
    seed = $urandom(32'd2024);
    repeat (5) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk_on = 1;
    chk("R1 reset cnt", cnt_o, 0);
    chk("R9 reset flag", uif_o, 0);
    chk("R10 reset dma", dma_o, 0);
    chk("R4 reset window", cmp_win_o, 1);

    // R1 period and R9 flag handling
    wr_psc(2); wr_arr(3); pulse_ug();
    flag_clr_i = 1; @(negedge clk_i); flag_clr_i = 0;
    ctl(1, 0, 0, 0, 0, 1, 1);
    gap(n); chk("R1 period", n, 12);
    chk("R9 irq", irq_o, 1);
    flag_clr_i = 1; @(negedge clk_i); flag_clr_i = 0;
    chk("R9 clear", uif_o, 0);

    // R5 mode change ignored while running
    ctl(1, 3, 1, 0, 0, 1, 1);
    chk("R5 dir kept", dir_o, 0);
    gap(n); chk("R5 mode kept", n, 12);

    // R6 preload
    ctl(1, 0, 0, 1, 0, 1, 1);
    wr_arr(1);
    to_pulse(mx); chk("R6 old limit", mx, 3);
    gap(n); chk("R6 new limit", n, 6);
    ctl(1, 0, 0, 0, 0, 1, 1);
    wr_arr(2);
    gap(n); chk("R6 immediate", n, 9);

    // R12 prescaler shadow
    do @(negedge clk_i); while (!dma_o);
    wr_psc(0);
    v = cnt_o; do @(negedge clk_i); while (cnt_o == v);
    v = cnt_o; n = 0;
    do begin @(negedge clk_i); n++; end while (cnt_o == v);
    chk("R12 old divider", n, 3);
    gap(n); chk("R12 new divider", n, 3);

    // R8 / R7 update generation
    wr_psc(2);
    ctl(1, 0, 0, 0, 1, 1, 1);
    ug_i = 1; flag_clr_i = 1; @(negedge clk_i); ug_i = 0; flag_clr_i = 0;
    chk("R8 flag quiet", uif_o, 0);
    chk("R8 no dma", dma_o, 0);
    chk("R7 restart", cnt_o, 0);
    @(negedge clk_i); chk("R7 wait 1", cnt_o, 0);
    @(negedge clk_i); chk("R7 wait 2", cnt_o, 0);
    @(negedge clk_i); chk("R7 first step", cnt_o, 1);
    ctl(1, 0, 0, 0, 0, 1, 1);
    pulse_ug(); chk("R8 any source", uif_o, 1);

    // R11 hold and clear
    repeat (4) @(negedge clk_i);
    ctl(0, 0, 0, 0, 0, 1, 1);
    v = cnt_o; chk("R11 running value", v, 1);
    repeat (5) @(negedge clk_i);
    chk("R11 hold", cnt_o, v);
    cnt_clr_i = 1; @(negedge clk_i); cnt_clr_i = 0;
    chk("R11 clear", cnt_o, 0);

    // R2 edge down
    ctl(0, 0, 1, 0, 0, 1, 1);
    wr_psc(0); wr_arr(4); pulse_ug();
    chk("R2 load", cnt_o, 4);
    chk("R2 dir", dir_o, 1);
    ctl(1, 0, 1, 0, 0, 1, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk("R2 count", cnt_o, (i < 4) ? 3 - i : 4);
    end
    chk("R2 underflow update", dma_o, 1);

    // R3 / R4 center, flags while up
    ctl(0, 0, 0, 0, 0, 1, 1);
    ctl(0, 2, 0, 0, 0, 1, 1);
    wr_arr(3); pulse_ug();
    ctl(1, 2, 0, 0, 0, 1, 1);
    begin
      int ec[7] = '{1, 2, 3, 2, 1, 0, 1};
      int ed[7] = '{0, 0, 0, 1, 1, 1, 0};
      int eu[7] = '{0, 0, 0, 1, 0, 0, 1};
      for (int i = 0; i < 7; i++) begin
        @(negedge clk_i);
        chk("R3 center cnt", cnt_o, ec[i]);
        chk("R3 center update", dma_o, eu[i]);
        chk("R4 up-phase window", cmp_win_o, 1 - ed[i]);
      end
    end
    // mode 1: flags while down
    ctl(0, 2, 0, 0, 0, 1, 1);
    ctl(0, 1, 0, 0, 0, 1, 1);
    chk("R4 mode1 up phase", cmp_win_o, 0);
    ctl(1, 1, 0, 0, 0, 1, 1);
    for (int i = 0; i < 10 && !dir_o; i++) @(negedge clk_i);
    chk("R4 mode1 down phase", cmp_win_o, 1);
    // mode 3: both
    ctl(0, 1, 0, 0, 0, 1, 1);
    ctl(0, 3, 0, 0, 0, 1, 1);
    chk("R4 mode3 up phase", cmp_win_o, 1);
    ctl(1, 3, 0, 0, 0, 1, 1);
    for (int i = 0; i < 10 && !dir_o; i++) @(negedge clk_i);
    chk("R4 mode3 down phase", cmp_win_o, 1);

    // constrained random against the model
    for (int r = 0; r < 40; r++) begin
      bit [1:0] md; bit dr, ap, us, ie, de;
      md = 2'($urandom % 4); dr = 1'($urandom % 2); ap = 1'($urandom % 2);
      us = 1'($urandom % 2); ie = 1'($urandom % 2); de = 1'($urandom % 2);
      ctl(0, md, dr, ap, us, ie, de);
      wr_psc($urandom % 4);
      wr_arr(1 + $urandom % 12);
      pulse_ug();
      ctl(1, md, dr, ap, us, ie, de);
      for (int c = 0; c < 400; c++) begin
        ug_i       = ($urandom % 64) == 0;
        cnt_clr_i  = ($urandom % 128) == 0;
        flag_clr_i = ($urandom % 8) == 0;
        arr_we_i   = ($urandom % 100) == 0;
        psc_we_i   = ($urandom % 100) == 0;
        wdata_i    = 16'($urandom % 13);
        ctl_we_i   = ($urandom % 200) == 0;
        en_i = ($urandom % 8) != 0; mode_i = 2'($urandom % 4); dir_i = 1'($urandom % 2);
        arpe_i = 1'($urandom % 2); urs_i = 1'($urandom % 2);
        uie_i = 1'($urandom % 2); ude_i = 1'($urandom % 2);
        @(negedge clk_i);
      end
      ug_i = 0; cnt_clr_i = 0; flag_clr_i = 0; arr_we_i = 0; psc_we_i = 0; ctl_we_i = 0;
      @(negedge clk_i);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule